// File: doc/BRIEF.md
# Byte-Steered Control Register Loader

This block sits behind an 8-bit host output port and turns a stream of byte writes into the contents of seven control registers. The host presents a byte and pulses a strobe. The block brings that strobe into its own clock domain, finds its rising edge, and accepts exactly one byte per pulse. Bit 7 of the byte tells the block what to do with it. With bit 7 clear, the low seven bits name a register to select. With bit 7 set, the low seven bits are stored in whichever register was selected most recently.

The selection is latched. Once a register is picked, any number of payload bytes can follow, and each one overwrites that same register. An address outside the seven-register range clears the selection. After that, payloads are dropped until a valid address arrives, and the same holds after reset. The register outputs drive the clock divisors, integration timer, transfer delay, device count, setup word and control word of the surrounding acquisition logic. Bit 5 of the control word chooses between capturing samples into memory and reading them back to the host.

Top module: `ppreg_loader`

## Requirements
- R1: After reset every register output is zero and `capture_mode` is 0.
- R2: A byte with bit 7 = 0 changes no register output. It only changes which register is selected.
- R3: A byte with bit 7 = 1 writes its bits 6:0 into the selected register, and no other register changes.
- R4: The selection persists. Successive payload bytes with no address byte between them all overwrite the same register.
- R5: Address values 0 through 6 select, in that order: `data_clk_div`, `sys_clk_div`, `integ_time`, `xfer_delay`, `dev_count`, `setup_cfg`, `ctrl_word`.
- R6: An address value from 7 to 127 selects no register. Payload bytes that follow it are discarded until a valid address arrives.
- R7: After reset no register is selected, so payload bytes are discarded until a valid address byte is received.
- R8: Each rising edge of `host_strobe` takes exactly one byte, sampled once. A change of `host_byte` while the strobe stays high has no effect.
- R9: `capture_mode` equals bit 5 of `ctrl_word`: 1 selects capture into memory and 0 selects readback to the host.
- R10: Suppose `host_strobe` rises between two clock edges. The written register keeps its old value through the second rising clock edge after the rise and shows the new value after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_byte | input | 8 | Byte from the host port; bit 7 = 1 means payload, 0 means address |
| host_strobe | input | 1 | Host write strobe, asynchronous to `clk`; a byte is taken on its rising edge |
| data_clk_div | output | 7 | Register at address 0 |
| sys_clk_div | output | 7 | Register at address 1 |
| integ_time | output | 7 | Register at address 2 |
| xfer_delay | output | 7 | Register at address 3 |
| dev_count | output | 7 | Register at address 4 |
| setup_cfg | output | 7 | Register at address 5 |
| ctrl_word | output | 7 | Register at address 6 |
| capture_mode | output | 1 | Bit 5 of `ctrl_word` |

## Verification
The hardest case to reach from the ports is a strobe that stays high while the byte under it changes. A design that writes on strobe level rather than on its edge gives itself away only there. The bench holds the strobe for many cycles with one payload, swaps in a different payload before releasing it, and checks that only the first value landed. The silent-discard paths are also hard to observe, because a dropped payload leaves nothing behind. For these, the bench sends payloads with no selection after reset and after out-of-range addresses, then reads every register that could have absorbed the write.

// File: rtl/ppreg_pkg.sv
package ppreg_pkg;

    localparam int NUM_REGS = 7;
    localparam int REG_W    = 7;
    localparam int BYTE_W   = 8;
    localparam int SEL_W    = $clog2(NUM_REGS);

    typedef enum logic [SEL_W-1:0] {
        IDX_DATA_CLK = 3'd0,
        IDX_SYS_CLK  = 3'd1,
        IDX_INTEG    = 3'd2,
        IDX_XFER     = 3'd3,
        IDX_DEVCNT   = 3'd4,
        IDX_SETUP    = 3'd5,
        IDX_CTRL     = 3'd6
    } reg_index_e;

    localparam int MODE_BIT = 5;

endpackage

// File: rtl/ppreg_strobe_edge.sv
module ppreg_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_async,
    output logic pulse_o
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } edge_state_t;

    edge_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.meta = strobe_async;
        s_d.sync = s_q.meta;
        s_d.prev = s_q.sync;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pulse_o = s_q.sync & ~s_q.prev;

    // One write per strobe: a pulse never lasts two cycles
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/ppreg_byte_decoder.sv
module ppreg_byte_decoder #(
    parameter int NREGS  = ppreg_pkg::NUM_REGS,
    parameter int BYTE_W = ppreg_pkg::BYTE_W,
    localparam int SEL_W = $clog2(NREGS),
    localparam int DW    = BYTE_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pulse_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              wr_en_o,
    output logic [SEL_W-1:0]  wr_idx_o,
    output logic [DW-1:0]     wr_data_o
);

    typedef struct packed {
        logic             valid;
        logic [SEL_W-1:0] idx;
    } sel_state_t;

    sel_state_t s_d, s_q;
    logic       is_payload;
    logic       addr_in_range;

    assign is_payload    = byte_i[BYTE_W-1];
    assign addr_in_range = (byte_i[DW-1:0] < DW'(NREGS));

    always_comb begin
        s_d       = s_q;
        wr_en_o   = 1'b0;
        wr_idx_o  = s_q.idx;
        wr_data_o = byte_i[DW-1:0];
        if (pulse_i) begin
            if (is_payload) begin
                wr_en_o = s_q.valid;
            end else if (addr_in_range) begin
                s_d.valid = 1'b1;
                s_d.idx   = byte_i[SEL_W-1:0];
            end else begin
                s_d.valid = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    // Payload bytes never disturb the latched selection
    p_payload_keeps_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i && is_payload) |=> ($stable(s_q.valid) && $stable(s_q.idx)));

    // Out-of-range address leaves nothing selected
    p_bad_addr_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i && !is_payload && !addr_in_range) |=> !s_q.valid);

    // Writes only issue while a selection is held
    p_write_needs_sel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (pulse_i && s_q.valid));

endmodule

// File: rtl/ppreg_bank.sv
module ppreg_bank #(
    parameter int NREGS = ppreg_pkg::NUM_REGS,
    parameter int DW    = ppreg_pkg::REG_W,
    localparam int SEL_W = $clog2(NREGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en_i,
    input  logic [SEL_W-1:0]          wr_idx_i,
    input  logic [DW-1:0]             wr_data_i,
    output logic [NREGS-1:0][DW-1:0]  regs_o
);

    typedef struct packed {
        logic [NREGS-1:0][DW-1:0] regs;
    } bank_state_t;

    bank_state_t      s_d, s_q;
    logic [NREGS-1:0] hit;

    for (genvar g = 0; g < NREGS; g++) begin : g_hit
        assign hit[g] = wr_en_i && (wr_idx_i == SEL_W'(g));
    end

    always_comb begin
        s_d = s_q;
        for (int i = 0; i < NREGS; i++) begin
            if (hit[i]) s_d.regs[i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign regs_o = s_q.regs;

    // Without a write strobe from the decoder, the bank holds
    p_hold_without_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(s_q.regs));

    // A write lands in the addressed register
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (s_q.regs[$past(wr_idx_i)] == $past(wr_data_i)));

    p_one_target_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

endmodule

// File: rtl/ppreg_loader.sv
module ppreg_loader
    import ppreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BYTE_W-1:0] host_byte,
    input  logic              host_strobe,
    output logic [REG_W-1:0]  data_clk_div,
    output logic [REG_W-1:0]  sys_clk_div,
    output logic [REG_W-1:0]  integ_time,
    output logic [REG_W-1:0]  xfer_delay,
    output logic [REG_W-1:0]  dev_count,
    output logic [REG_W-1:0]  setup_cfg,
    output logic [REG_W-1:0]  ctrl_word,
    output logic              capture_mode
);

    logic                           pulse;
    logic                           wr_en;
    logic [SEL_W-1:0]               wr_idx;
    logic [REG_W-1:0]               wr_data;
    logic [NUM_REGS-1:0][REG_W-1:0] regs;

    ppreg_strobe_edge u_edge (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe_async (host_strobe),
        .pulse_o      (pulse)
    );

    ppreg_byte_decoder #(.NREGS(NUM_REGS), .BYTE_W(BYTE_W)) u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .pulse_i   (pulse),
        .byte_i    (host_byte),
        .wr_en_o   (wr_en),
        .wr_idx_o  (wr_idx),
        .wr_data_o (wr_data)
    );

    ppreg_bank #(.NREGS(NUM_REGS), .DW(REG_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .regs_o    (regs)
    );

    assign data_clk_div = regs[IDX_DATA_CLK];
    assign sys_clk_div  = regs[IDX_SYS_CLK];
    assign integ_time   = regs[IDX_INTEG];
    assign xfer_delay   = regs[IDX_XFER];
    assign dev_count    = regs[IDX_DEVCNT];
    assign setup_cfg    = regs[IDX_SETUP];
    assign ctrl_word    = regs[IDX_CTRL];
    assign capture_mode = ctrl_word[MODE_BIT];

    // Mode output follows the stored control word one cycle after its write
    p_mode_tracks_ctrl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_CTRL) |=> (capture_mode == $past(wr_data[MODE_BIT])));

endmodule

// File: tb/ppreg_loader_test.sv
module ppreg_loader_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] host_byte = 8'h00;
    logic       host_strobe = 1'b0;
    logic [6:0] o0, o1, o2, o3, o4, o5, o6;
    logic       capture_mode;
    logic [6:0] obs [7];
    int         n_cmp = 0;
    int         n_bad = 0;
    bit         done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    ppreg_loader uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_byte    (host_byte),
        .host_strobe  (host_strobe),
        .data_clk_div (o0),
        .sys_clk_div  (o1),
        .integ_time   (o2),
        .xfer_delay   (o3),
        .dev_count    (o4),
        .setup_cfg    (o5),
        .ctrl_word    (o6),
        .capture_mode (capture_mode)
    );

    assign obs[0] = o0;
    assign obs[1] = o1;
    assign obs[2] = o2;
    assign obs[3] = o3;
    assign obs[4] = o4;
    assign obs[5] = o5;
    assign obs[6] = o6;

    // {byte[7:0], check_index[2:0], expected[6:0]}
    localparam int NVEC = 20;
    localparam logic [17:0] VEC [NVEC] = '{
        {8'h85, 3'd0, 7'h00},  // R7 payload with nothing selected
        {8'hC1, 3'd1, 7'h00},  // R7
        {8'h02, 3'd2, 7'h00},  // R2 address only
        {8'h9A, 3'd2, 7'h1A},  // R3
        {8'hC5, 3'd2, 7'h45},  // R4 same register again
        {8'h06, 3'd2, 7'h45},  // R2
        {8'hA0, 3'd6, 7'h20},  // R5 control
        {8'h00, 3'd6, 7'h20},  // R2
        {8'hFF, 3'd0, 7'h7F},  // R5 address 0
        {8'h01, 3'd0, 7'h7F},
        {8'h81, 3'd1, 7'h01},  // R5 address 1
        {8'h03, 3'd2, 7'h45},
        {8'h93, 3'd3, 7'h13},  // R5 address 3
        {8'h04, 3'd3, 7'h13},
        {8'hA4, 3'd4, 7'h24},  // R5 address 4
        {8'h05, 3'd4, 7'h24},
        {8'hB5, 3'd5, 7'h35},  // R5 address 5
        {8'h07, 3'd5, 7'h35},  // R6 invalid address
        {8'h8F, 3'd5, 7'h35},  // R6 payload dropped
        {8'h7F, 3'd6, 7'h20}   // R6 invalid address
    };

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        host_byte   = b;
        host_strobe = 1'b1;
        repeat (5) @(negedge clk);
        host_strobe = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic chk_all_zero(input string tag);
        for (int i = 0; i < 7; i++) chk(tag, obs[i], 0);
        chk(tag, capture_mode, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (4) @(negedge clk);
        chk_all_zero("R1 reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector walk
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v][17:10]);
            chk($sformatf("vec %0d", v), obs[VEC[v][9:7]], VEC[v][6:0]);
        end
        // After the invalid address every register still holds its value (R6)
        chk("R6 r0", obs[0], 7'h7F);
        send(8'hEE);
        chk("R6 r6 after payload", obs[6], 7'h20);
        chk("R6 r1 after payload", obs[1], 7'h01);

        // Mode bit (R9)
        send(8'h06);
        send(8'hA0);
        chk("R9 capture", capture_mode, 1);
        send(8'hDF);
        chk("R9 bit5 clear", capture_mode, 0);
        chk("R9 ctrl", obs[6], 7'h5F);

        // Byte changed while strobe held high (R8)
        send(8'h01);
        @(negedge clk);
        host_byte   = 8'h8A;
        host_strobe = 1'b1;
        repeat (8) @(negedge clk);
        host_byte   = 8'h95;
        repeat (8) @(negedge clk);
        host_strobe = 1'b0;
        repeat (5) @(negedge clk);
        chk("R8 single sample", obs[1], 7'h0A);

        // Latency (R10)
        send(8'h03);
        @(negedge clk);
        host_byte   = 8'hC2;
        host_strobe = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R10 old after 2 edges", obs[3], 7'h13);
        @(negedge clk);
        chk("R10 new after 3 edges", obs[3], 7'h42);
        host_strobe = 1'b0;
        repeat (5) @(negedge clk);

        // Reset clears bank and selection (R1, R7)
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk_all_zero("R1 second reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        send(8'hFF);
        chk_all_zero("R7 selection cleared by reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule